// File: doc/BRIEF.md
# Token-Passing Bus Slave Protocol Engine

This engine is the protocol layer of a slave on an 8-bit shared parallel bus where a single write token moves back and forth between one master and one slave. It sits above a port block that handles the strobe timing. The port block hands the engine each byte the master writes and tells it when the master has collected a byte the engine offered. The engine uses these byte events to sequence commands and frames.

After reset the engine is unsynchronised. It consumes and drops every master byte until a resynchronise command arrives. It then consumes the end-of-message byte, answers with the acknowledge command, and returns the token. From then on it alternates turns with the master. On the master's turn it decodes a command byte:
- A null command passes the token to the slave.
- A transfer command carries a length and a frame of data, which the engine stores in a bounded receive buffer.
- A resync command starts a fresh handshake.
- Any other code is a protocol error and drops the engine back to unsynchronised.

On the engine's own turn it sends a frame from the local application if an output request is pending and the data is ready. If no request is pending, it passes the token back with a null command. If a request is pending but the data is not ready, it keeps the token.

Top module: `tps_slave_engine`

## Requirements
- R1: After reset `synced`, `token_held` and `out_valid` are low. While unsynchronised, every master byte other than 0x5A is consumed (`rx_ack` high with `rx_valid`) and changes no output.
- R2: A master byte 0x5A received while unsynchronised sets `synced`. The engine then consumes one further master byte (end-of-message) and offers 0x07 followed by 0x00. When the master takes the 0x00, the token returns to the master.
- R3: A master end-of-message byte (the byte that follows a null command or completes a frame) is consumed and never stored. The cycle after it is consumed, `token_held` is high.
- R4: If no output request is pending when the engine holds the token, it offers 0x00 (null) and then 0x00 (end-of-message), and then releases the token.
- R5: While a request is pending (a `tx_req` pulse was seen and no frame has finished since) and `tx_ready` is low, the engine keeps the token and offers nothing.
- R6: With a request pending and `tx_ready` high, the engine offers 0x01, then `tx_len`, then `tx_byte` for `tx_idx` = 0 to len-1, then 0x00. When the master takes the final byte, `tx_done` pulses for one cycle and the request clears.
- R7: A master frame of command 0x01, length L and L data bytes is stored from buffer index 0 upward and can be read back at `rd_idx`. After the end-of-message byte, `frame_pulse` goes high for one cycle with `frame_len` = L. L = 0 is allowed.
- R8: If L exceeds min(`rx_cap`, DEPTH), `frame_len` is reported as 0. All of the frame's bytes are still consumed, and the next command decodes normally.
- R9: A command byte on the master's turn that is not 0x00, 0x01 or 0x5A clears `synced` and returns the engine to waiting for resync.
- R10: A 0x5A command on the master's turn while synchronised runs the same handshake as R2.
- R11: An offered byte stays valid, with unchanged data, until `out_taken` is seen.
- R12: `token_held` is high only while `synced` is high, and no master byte is consumed while the engine holds the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | The master has written a byte (one cycle) |
| rx_data | input | 8 | The byte written by the master |
| rx_ack | output | 1 | The byte is consumed this cycle (releases the handshake) |
| out_valid | output | 1 | The engine offers a byte for the master to read |
| out_data | output | 8 | The offered byte |
| out_taken | input | 1 | The master has read the offered byte |
| tx_req | input | 1 | Pulse: post an output request |
| tx_ready | input | 1 | Outgoing frame data is ready |
| tx_len | input | 8 | Outgoing frame length |
| tx_idx | output | 8 | Index of the outgoing data byte wanted |
| tx_byte | input | 8 | Outgoing data byte at `tx_idx` |
| rx_cap | input | 8 | Receive capacity offered by the application |
| rd_idx | input | AW | Receive buffer read index |
| rd_data | output | 8 | Receive buffer byte at `rd_idx` |
| token_held | output | 1 | The engine owns the write token |
| synced | output | 1 | The resync handshake has been seen |
| frame_pulse | output | 1 | One-cycle pulse: a frame was received |
| frame_len | output | 8 | Reported length of the last frame |
| tx_done | output | 1 | One-cycle pulse: an outgoing frame completed |

## Verification
The bench goes after these corner cases:
- Garbage bytes before the first resync. An engine that decoded them would answer with bytes or claim the token.
- A pending request with data that is not ready. An engine that got this wrong would emit a null command and give the token away.
- Zero-length frames and frames larger than either the application capacity or the physical buffer. A wrong engine would report a non-zero length for an oversize frame, or lose byte alignment and misread the next command.
- An illegal command after sync, and a resync in the middle of a session. A wrong engine would keep `synced` high or fail to acknowledge.
- Slow master reads. These expose an offered byte that changes or disappears before it is taken.

// File: rtl/tps_pkg.sv
// Package: shared command codes and engine state encoding.
// Assumes all codes are one byte wide.
package tps_pkg;
    localparam logic [7:0] CODE_NULL  = 8'h00;
    localparam logic [7:0] CODE_XFER  = 8'h01;
    localparam logic [7:0] CODE_ACK   = 8'h07;
    localparam logic [7:0] CODE_SYNC  = 8'h5A;
    localparam logic [7:0] CODE_EOM   = 8'h00;

    typedef enum logic [3:0] {
        ST_WAIT_SYNC,
        ST_SYNC_EOM,
        ST_ACK_CODE,
        ST_ACK_EOM,
        ST_M_TURN,
        ST_RX_LEN,
        ST_RX_DATA,
        ST_RX_FEOM,
        ST_RX_NEOM,
        ST_S_TURN,
        ST_TX_NULL,
        ST_TX_NEOM,
        ST_TX_CMD,
        ST_TX_LEN,
        ST_TX_DATA,
        ST_TX_FEOM
    } eng_state_t;
endpackage

// File: rtl/tps_req_flag.sv
// Module: holds the pending output request.
// A set pulse wins over a clear in the same cycle, so a new request is never lost.
module tps_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic pending
);
    // Purpose: set/clear register for the request, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_req) pending <= 1'b1;
        else if (clr_req) pending <= 1'b0;
    end

    p_req_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !clr_req |=> pending);
    p_req_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> pending);
endmodule

// File: rtl/tps_rx_buf.sv
// Module: receive frame store with one write port and one asynchronous read port.
// Assumes the writer keeps waddr below DEPTH. Contents are not reset.
module tps_rx_buf #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Purpose: store one received data byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Purpose: present the byte at the read index.
    always_comb rdata = mem[raddr];

    p_waddr_range_r7: assert property (@(posedge clk) we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/tps_slave_engine.sv
// Module: slave protocol engine for the token-passing parallel bus.
// Each rx_valid is one master byte that the port block has already strobed in.
// Each out_taken means the master has read the byte offered on out_data.
// DEPTH must not exceed 255.
module tps_slave_engine
    import tps_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          rx_ack,
    output logic          out_valid,
    output logic [7:0]    out_data,
    input  logic          out_taken,
    input  logic          tx_req,
    input  logic          tx_ready,
    input  logic [7:0]    tx_len,
    output logic [7:0]    tx_idx,
    input  logic [7:0]    tx_byte,
    input  logic [7:0]    rx_cap,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          token_held,
    output logic          synced,
    output logic          frame_pulse,
    output logic [7:0]    frame_len,
    output logic          tx_done
);
    localparam logic [8:0] CAP_LIMIT = 9'(DEPTH);

    eng_state_t state;
    logic [7:0] rx_len_q;
    logic [7:0] rx_cnt_q;
    logic       fits_q;
    logic [7:0] tx_len_q;
    logic [7:0] tx_idx_q;
    logic       pending;
    logic [8:0] eff_cap;
    logic       len_fits;
    logic       rx_state;
    logic       buf_we;
    logic       req_clr;

    // Purpose: the capacity actually usable is the smaller of the offered and the physical.
    always_comb begin
        eff_cap  = (9'(rx_cap) > CAP_LIMIT) ? CAP_LIMIT : 9'(rx_cap);
        len_fits = ({1'b0, rx_data} <= eff_cap);
    end

    // Purpose: decode which states take master bytes and which hold the token.
    always_comb begin
        rx_state = (state == ST_WAIT_SYNC) || (state == ST_SYNC_EOM) ||
                   (state == ST_M_TURN)    || (state == ST_RX_LEN)   ||
                   (state == ST_RX_DATA)   || (state == ST_RX_FEOM)  ||
                   (state == ST_RX_NEOM);
        rx_ack     = rx_valid && rx_state;
        token_held = !rx_state;
        out_valid  = !rx_state && (state != ST_S_TURN);
    end

    // Purpose: choose the byte offered to the master in each sending state.
    always_comb begin
        unique case (state)
            ST_ACK_CODE: out_data = CODE_ACK;
            ST_TX_CMD:   out_data = CODE_XFER;
            ST_TX_LEN:   out_data = tx_len_q;
            ST_TX_DATA:  out_data = tx_byte;
            ST_TX_NULL:  out_data = CODE_NULL;
            default:     out_data = CODE_EOM;
        endcase
    end

    assign tx_idx  = tx_idx_q;
    assign buf_we  = rx_valid && (state == ST_RX_DATA) && fits_q;
    assign req_clr = (state == ST_TX_FEOM) && out_taken;

    // Purpose: main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_WAIT_SYNC;
            synced      <= 1'b0;
            rx_len_q    <= 8'd0;
            rx_cnt_q    <= 8'd0;
            fits_q      <= 1'b0;
            tx_len_q    <= 8'd0;
            tx_idx_q    <= 8'd0;
            frame_pulse <= 1'b0;
            frame_len   <= 8'd0;
            tx_done     <= 1'b0;
        end else begin
            frame_pulse <= 1'b0;
            tx_done     <= 1'b0;
            unique case (state)
                ST_WAIT_SYNC: if (rx_valid && rx_data == CODE_SYNC) begin
                    synced <= 1'b1;
                    state  <= ST_SYNC_EOM;
                end
                ST_SYNC_EOM: if (rx_valid) state <= ST_ACK_CODE;
                ST_ACK_CODE: if (out_taken) state <= ST_ACK_EOM;
                ST_ACK_EOM:  if (out_taken) state <= ST_M_TURN;
                ST_M_TURN: if (rx_valid) begin
                    if (rx_data == CODE_XFER)      state <= ST_RX_LEN;
                    else if (rx_data == CODE_NULL) state <= ST_RX_NEOM;
                    else if (rx_data == CODE_SYNC) state <= ST_SYNC_EOM;
                    else begin
                        synced <= 1'b0;
                        state  <= ST_WAIT_SYNC;
                    end
                end
                ST_RX_LEN: if (rx_valid) begin
                    rx_len_q <= rx_data;
                    rx_cnt_q <= 8'd0;
                    fits_q   <= len_fits;
                    state    <= (rx_data == 8'd0) ? ST_RX_FEOM : ST_RX_DATA;
                end
                ST_RX_DATA: if (rx_valid) begin
                    rx_cnt_q <= rx_cnt_q + 8'd1;
                    if (rx_cnt_q == rx_len_q - 8'd1) state <= ST_RX_FEOM;
                end
                ST_RX_FEOM: if (rx_valid) begin
                    frame_pulse <= 1'b1;
                    frame_len   <= fits_q ? rx_len_q : 8'd0;
                    state       <= ST_S_TURN;
                end
                ST_RX_NEOM: if (rx_valid) state <= ST_S_TURN;
                ST_S_TURN: begin
                    if (!pending) state <= ST_TX_NULL;
                    else if (tx_ready) begin
                        tx_len_q <= tx_len;
                        tx_idx_q <= 8'd0;
                        state    <= ST_TX_CMD;
                    end
                end
                ST_TX_NULL: if (out_taken) state <= ST_TX_NEOM;
                ST_TX_NEOM: if (out_taken) state <= ST_M_TURN;
                ST_TX_CMD:  if (out_taken) state <= ST_TX_LEN;
                ST_TX_LEN:  if (out_taken)
                    state <= (tx_len_q == 8'd0) ? ST_TX_FEOM : ST_TX_DATA;
                ST_TX_DATA: if (out_taken) begin
                    tx_idx_q <= tx_idx_q + 8'd1;
                    if (tx_idx_q == tx_len_q - 8'd1) state <= ST_TX_FEOM;
                end
                ST_TX_FEOM: if (out_taken) begin
                    tx_done <= 1'b1;
                    state   <= ST_M_TURN;
                end
                default: state <= ST_WAIT_SYNC;
            endcase
        end
    end

    tps_req_flag u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (tx_req),
        .clr_req (req_clr),
        .pending (pending)
    );

    tps_rx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (rx_cnt_q[AW-1:0]),
        .wdata (rx_data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    p_token_needs_sync_r12: assert property (@(posedge clk) disable iff (!rst_n)
        token_held |-> synced);
    p_no_take_with_token_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> !token_held);
    p_offer_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_taken |=> out_valid);
    p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (9'(frame_len) <= CAP_LIMIT));
    p_done_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !token_held && $past(out_valid && out_taken));
    p_sync_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(synced) |-> state == ST_WAIT_SYNC);
endmodule

// File: tb/tps_slave_engine_tb.sv
module tps_slave_engine_tb;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int AW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'd0;
    logic          rx_ack;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_taken = 1'b0;
    logic          tx_req = 1'b0;
    logic          tx_ready = 1'b0;
    logic [7:0]    tx_len = 8'd0;
    logic [7:0]    tx_idx;
    logic [7:0]    tx_byte;
    logic [7:0]    rx_cap = 8'd8;
    logic [AW-1:0] rd_idx = '0;
    logic [7:0]    rd_data;
    logic          token_held, synced, frame_pulse, tx_done;
    logic [7:0]    frame_len;

    logic [7:0] tx_mem [256];
    int nchk = 0;
    int nerr = 0;
    logic [7:0] got_q [$];
    bit saw_done = 0;

    always #(PERIOD/2) clk = ~clk;
    assign tx_byte = tx_mem[tx_idx];

    tps_slave_engine #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ack(rx_ack), .out_valid(out_valid), .out_data(out_data),
        .out_taken(out_taken), .tx_req(tx_req), .tx_ready(tx_ready),
        .tx_len(tx_len), .tx_idx(tx_idx), .tx_byte(tx_byte), .rx_cap(rx_cap),
        .rd_idx(rd_idx), .rd_data(rd_data), .token_held(token_held),
        .synced(synced), .frame_pulse(frame_pulse), .frame_len(frame_len),
        .tx_done(tx_done)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  ph = 0;          // 0 wait,1 sync eom,2 master turn,3 len,4 data,5 frame eom,6 null eom,7 own turn,8 sending
    bit  m_sync = 0, m_fp = 0, m_done = 0, m_pend = 0, q_frame = 0, rfit = 0, started = 0;
    int  m_flen = 0, rlen = 0, rcnt = 0;
    logic [7:0] q_out [$];

    always @(posedge clk) begin
        bit clr;
        int cap;
        clr = 0;
        started = 1;
        if (!rst_n) begin
            ph = 0; m_sync = 0; m_fp = 0; m_done = 0; m_pend = 0; q_out.delete();
        end else begin
            m_fp = 0; m_done = 0;
            cap = (int'(rx_cap) > DEPTH) ? DEPTH : int'(rx_cap);
            case (ph)
                0: if (rx_valid && rx_data == 8'h5A) begin m_sync = 1; ph = 1; end
                1: if (rx_valid) begin q_out = '{8'h07, 8'h00}; q_frame = 0; ph = 8; end
                2: if (rx_valid) begin
                    if (rx_data == 8'h01) ph = 3;
                    else if (rx_data == 8'h00) ph = 6;
                    else if (rx_data == 8'h5A) ph = 1;
                    else begin m_sync = 0; ph = 0; end
                end
                3: if (rx_valid) begin
                    rlen = rx_data; rcnt = 0; rfit = (rlen <= cap);
                    ph = (rlen == 0) ? 5 : 4;
                end
                4: if (rx_valid) begin rcnt++; if (rcnt == rlen) ph = 5; end
                5: if (rx_valid) begin m_fp = 1; m_flen = rfit ? rlen : 0; ph = 7; end
                6: if (rx_valid) ph = 7;
                7: if (!m_pend) begin q_out = '{8'h00, 8'h00}; q_frame = 0; ph = 8; end
                   else if (tx_ready) begin
                       q_out.delete();
                       q_out.push_back(8'h01);
                       q_out.push_back(tx_len);
                       for (int i = 0; i < int'(tx_len); i++) q_out.push_back(tx_mem[i]);
                       q_out.push_back(8'h00);
                       q_frame = 1; ph = 8;
                   end
                8: if (out_taken) begin
                    void'(q_out.pop_front());
                    if (q_out.size() == 0) begin
                        ph = 2;
                        if (q_frame) begin m_done = 1; clr = 1; end
                    end
                end
                default: ph = 0;
            endcase
            if (tx_req) m_pend = 1;
            else if (clr) m_pend = 0;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R12 token_held", token_held, (ph == 7 || ph == 8));
            chk("R9 synced", synced, m_sync);
            chk("R1 rx_ack", rx_ack, rx_valid && ph <= 6);
            chk("R11 out_valid", out_valid, ph == 8);
            if (ph == 8) chk("R6 out_data", out_data, q_out[0]);
            chk("R7 frame_pulse", frame_pulse, m_fp);
            if (m_fp) chk("R7 frame_len", frame_len, m_flen);
            chk("R6 tx_done", tx_done, m_done);
            if (tx_done) saw_done = 1;
        end
    end

    // ---------------- stimulus ----------------
    task automatic mwrite(logic [7:0] b);
        @(negedge clk); #1; rx_valid = 1'b1; rx_data = b;
        @(negedge clk); #1; rx_valid = 1'b0;
    endtask

    task automatic drain(int gap);
        got_q.delete();
        saw_done = 0;
        for (int g = 0; g < 300; g++) begin
            logic [7:0] b;
            @(negedge clk); #1;
            if (!token_held) break;
            if (out_valid) begin
                b = out_data;
                repeat (gap) @(negedge clk);
                #1;
                chk("R11 offer held", {out_valid, out_data}, {1'b1, b});
                got_q.push_back(b);
                out_taken = 1'b1;
                @(negedge clk); #1; out_taken = 1'b0;
            end
        end
    endtask

    task automatic chk_got(string tag, logic [7:0] exp [$]);
        chk({tag, " count"}, got_q.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got_q.size(); i++)
            chk({tag, " byte"}, got_q[i], exp[i]);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) tx_mem[i] = 8'(8'h30 + i * 7);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 synced after reset", synced, 0);
        chk("R1 token after reset", token_held, 0);
        chk("R1 out_valid after reset", out_valid, 0);

        // R1: junk before sync
        mwrite(8'h01); mwrite(8'h33); mwrite(8'h00);
        chk("R1 junk ignored synced", synced, 0);
        chk("R1 junk ignored out_valid", out_valid, 0);

        // R2: sync handshake
        mwrite(8'h5A); mwrite(8'h00);
        drain(0);
        chk_got("R2 ack", '{8'h07, 8'h00});
        chk("R2 synced", synced, 1);
        chk("R2 token returned", token_held, 0);

        // R3/R4: master null then engine null
        mwrite(8'h00); mwrite(8'h00);
        chk("R3 token after EOM", token_held, 1);
        drain(1);
        chk_got("R4 null", '{8'h00, 8'h00});

        // R7: three-byte frame
        rx_cap = 8'd8;
        mwrite(8'h01); mwrite(8'h03); mwrite(8'hA1); mwrite(8'hB2); mwrite(8'hC3); mwrite(8'h00);
        chk("R7 frame_pulse", frame_pulse, 1);
        chk("R7 frame_len", frame_len, 3);
        drain(0);
        chk_got("R4 null after frame", '{8'h00, 8'h00});
        rd_idx = 0; #1 chk("R7 buf0", rd_data, 8'hA1);
        rd_idx = 1; #1 chk("R7 buf1", rd_data, 8'hB2);
        rd_idx = 2; #1 chk("R7 buf2", rd_data, 8'hC3);

        // R5/R6: pending request, data late
        @(negedge clk); #1 tx_req = 1'b1;
        @(negedge clk); #1 tx_req = 1'b0;
        mwrite(8'h00); mwrite(8'h00);
        repeat (8) @(negedge clk);
        #1;
        chk("R5 token kept", token_held, 1);
        chk("R5 nothing offered", out_valid, 0);
        tx_len = 8'd4; tx_ready = 1'b1;
        drain(2);
        tx_ready = 1'b0;
        chk_got("R6 frame", '{8'h01, 8'h04, tx_mem[0], tx_mem[1], tx_mem[2], tx_mem[3], 8'h00});
        chk("R6 tx_done seen", saw_done, 1);
        mwrite(8'h00); mwrite(8'h00);
        drain(0);
        chk_got("R6 request cleared", '{8'h00, 8'h00});

        // R7: zero-length frame
        mwrite(8'h01); mwrite(8'h00); mwrite(8'h00);
        chk("R7 zero frame pulse", frame_pulse, 1);
        chk("R7 zero frame len", frame_len, 0);
        drain(0);

        // R8: oversize against offered capacity
        rx_cap = 8'd2;
        mwrite(8'h01); mwrite(8'h05);
        for (int i = 0; i < 5; i++) mwrite(8'(8'h90 + i));
        mwrite(8'h00);
        chk("R8 oversize len", frame_len, 0);
        chk("R8 oversize pulse", frame_pulse, 1);
        drain(0);
        chk_got("R8 aligned null", '{8'h00, 8'h00});
        mwrite(8'h01); mwrite(8'h02); mwrite(8'h05); mwrite(8'h06); mwrite(8'h00);
        chk("R8 fitting len", frame_len, 2);
        drain(0);
        rd_idx = 0; #1 chk("R8 buf0", rd_data, 8'h05);
        rd_idx = 1; #1 chk("R8 buf1", rd_data, 8'h06);

        // R8: oversize against physical depth
        rx_cap = 8'd40;
        mwrite(8'h01); mwrite(8'(DEPTH + 1));
        for (int i = 0; i <= DEPTH; i++) mwrite(8'(i));
        mwrite(8'h00);
        chk("R8 depth limit len", frame_len, 0);
        drain(0);

        // R10: resync mid-session
        mwrite(8'h5A); mwrite(8'h00);
        drain(0);
        chk_got("R10 ack", '{8'h07, 8'h00});
        chk("R10 synced", synced, 1);

        // R9: illegal command
        mwrite(8'h22);
        chk("R9 synced dropped", synced, 0);
        chk("R12 no token unsynced", token_held, 0);
        mwrite(8'h01);
        chk("R9 still waiting", synced, 0);
        chk("R9 nothing offered", out_valid, 0);
        mwrite(8'h5A); mwrite(8'h00);
        drain(0);
        chk_got("R9 resync ack", '{8'h07, 8'h00});

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule